// File: doc/BRIEF.md
# Descriptor-Driven Strided Transfer Engine

This block is the address-generation side of a data mover that sits between a main-memory port and a local scratchpad. A host writes transfer descriptors, one whole descriptor per write, into a small descriptor store held apart from the data memories. It then pulses `start` together with the index of the first descriptor. The engine walks that descriptor and, when chained, the ones that follow it. For each element it issues one access on the main-memory port and one on the local port, and it moves a single data word per accepted main-memory cycle.

Each descriptor describes one strided stream. The main address starts at a base and moves by a signed word stride. The local address starts at its own base and moves up by one. A direction bit chooses whether data flows from main memory into local memory or the other way. Several external memory modules share one address bus, and a one-hot chip-select picks the module named in the descriptor. A job ends at the descriptor that carries the last flag, and the engine then gives a one-cycle done pulse.

Top module: `strx_engine`

## Requirements
- R1: A host write (`cfg_we` high at a clock edge while `busy` is low) stores `cfg_wdata` in slot `cfg_waddr`, and `cfg_rdata` always shows the slot chosen by `cfg_raddr`. Descriptor layout with default parameters, from bit 0 upward: bit 0 = last flag, bits 2:1 = module select, bit 3 = direction, bits 19:4 = element count, bits 35:20 = signed stride in words, bits 51:36 = local base, bits 83:52 = main base.
- R2: `busy` is low after reset and high from the cycle after an accepted start until the cycle after the done pulse. A descriptor write made while `busy` is high leaves the stored descriptor unchanged.
- R3: A `start` pulse while idle begins a job at descriptor `start_idx`. A `start` pulse while busy has no effect on the running job.
- R4: Element k of a descriptor (k = 0 .. count-1) uses main address base + k*stride, with the stride sign-extended and the sum taken modulo 2^32, and local address local base + k, modulo 2^16. Elements come out in increasing k.
- R5: With direction 0, each element reads main memory (`mm_we`=0) and writes local memory (`lm_we`=1 in the accepted cycle, `lm_wdata` = `mm_rdata`). With direction 1, each element reads local memory (`lm_we`=0) and writes main memory (`mm_we`=1, `mm_wdata` = `lm_rdata`).
- R6: An element is accepted only in a cycle where `mm_req` and `mm_ready` are both high. While `mm_ready` is low, the request and both addresses hold their values.
- R7: While `mm_req` is high, `mm_cs` has exactly bit `sel` set (for sel below the module count). While `mm_req` is low, `mm_cs` is zero.
- R8: After a descriptor without the last flag, the engine goes on with the next index, wrapping from the highest slot to slot 0.
- R9: A descriptor with a count of zero makes no memory access, and the chain goes on past it.
- R10: After the last element of the descriptor marked last, or after that descriptor is skipped, `done` is high for exactly one cycle. The engine is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_waddr | input | 3 | Descriptor slot to write |
| cfg_wdata | input | 84 | Descriptor word to write |
| cfg_raddr | input | 3 | Descriptor slot to read back |
| cfg_rdata | output | 84 | Read-back descriptor word |
| start | input | 1 | Job start pulse |
| start_idx | input | 3 | First descriptor of the job |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |
| mm_req | output | 1 | Main-memory access request |
| mm_we | output | 1 | Main-memory write enable |
| mm_cs | output | 4 | One-hot memory module select |
| mm_addr | output | 32 | Main-memory word address |
| mm_wdata | output | 32 | Main-memory write data |
| mm_rdata | input | 32 | Main-memory read data, valid with mm_ready |
| mm_ready | input | 1 | Main memory accepts the access this cycle |
| lm_req | output | 1 | Local-memory access request |
| lm_we | output | 1 | Local-memory write enable |
| lm_addr | output | 16 | Local-memory word address |
| lm_wdata | output | 32 | Local-memory write data |
| lm_rdata | input | 32 | Local-memory read data (combinational) |

## Verification
Single descriptors are run with a positive stride into local memory and with a negative stride out of local memory. These show whether the signed stride, the direction bit and the module select are each applied. A chain that wraps from the top slot back to slot 0 and holds a zero-count descriptor tells correct chaining apart from off-by-one indexing and from wrongly accessing an empty descriptor. A long job with random stalls, a descriptor write and a second start pulse made while it runs separates a correct hold and lock from state that leaks through. Random multi-descriptor jobs with random ready patterns then cover general combinations of the fields.

// File: rtl/strx_pkg.sv
package strx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_XFER  = 3'd2,
      ST_NEXT  = 3'd3,
      ST_FIN   = 3'd4
   } strx_state_e;
endpackage

// File: rtl/strx_desc_mem.sv
module strx_desc_mem #(
   parameter int DEPTH  = 8,
   parameter int DESC_W = 84,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DESC_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DESC_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DESC_W-1:0] rd_data_b
);
   logic [DESC_W-1:0] slots [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slots[g] <= '0;
            else if (wr_en && !lock && (wr_idx == IDX_W'(g)))
               slots[g] <= wr_data;
         end
      end
   endgenerate

   assign rd_data_a = slots[rd_idx_a];
   assign rd_data_b = slots[rd_idx_b];

   // R2
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && wr_en) |=> (slots[$past(wr_idx)] == $past(slots[wr_idx])));
endmodule

// File: rtl/strx_addr_gen.sv
module strx_addr_gen #(
   parameter int MM_AW    = 32,
   parameter int LM_AW    = 16,
   parameter int STRIDE_W = 16,
   parameter int CNT_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic [MM_AW-1:0]    mm_base,
   input  logic [LM_AW-1:0]    lm_base,
   input  logic [STRIDE_W-1:0] stride,
   input  logic [CNT_W-1:0]    count,
   output logic [MM_AW-1:0]    mm_addr,
   output logic [LM_AW-1:0]    lm_addr,
   output logic                final_elem
);
   logic [MM_AW-1:0] stride_ext;
   logic [MM_AW-1:0] mm_ptr;
   logic [LM_AW-1:0] lm_ptr;
   logic [CNT_W-1:0] remain;

   generate
      if (STRIDE_W < MM_AW) begin : g_sext
         assign stride_ext = {{(MM_AW-STRIDE_W){stride[STRIDE_W-1]}}, stride};
      end else begin : g_trunc
         assign stride_ext = stride[MM_AW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mm_ptr <= '0;
         lm_ptr <= '0;
         remain <= '0;
      end else if (load) begin
         mm_ptr <= mm_base;
         lm_ptr <= lm_base;
         remain <= count;
      end else if (step) begin
         mm_ptr <= mm_ptr + stride_ext;
         lm_ptr <= lm_ptr + LM_AW'(1);
         remain <= remain - CNT_W'(1);
      end
   end

   assign mm_addr    = mm_ptr;
   assign lm_addr    = lm_ptr;
   assign final_elem = (remain == CNT_W'(1));

   // R4
   stride_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (mm_ptr == $past(mm_ptr) + $past(stride_ext)) &&
                          (lm_ptr == $past(lm_ptr) + LM_AW'(1)));
   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> ($stable(mm_ptr) && $stable(lm_ptr) && $stable(remain)));
endmodule

// File: rtl/strx_cs_dec.sv
module strx_cs_dec #(
   parameter int N_MOD = 4,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [N_MOD-1:0] cs
);
   generate
      for (genvar g = 0; g < N_MOD; g++) begin : g_cs
         assign cs[g] = en && (sel == SEL_W'(g));
      end
   endgenerate

   // R7
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));
   // R7
   cs_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (int'(sel) < N_MOD)) |-> ($countones(cs) == 1));
endmodule

// File: rtl/strx_seq.sv
module strx_seq
   import strx_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] start_idx,
   input  logic             cnt_zero,
   input  logic             desc_last,
   input  logic             final_elem,
   input  logic             mm_ready,
   output logic [IDX_W-1:0] idx,
   output logic             load,
   output logic             step,
   output logic             active,
   output logic             busy,
   output logic             done
);
   strx_state_e state, state_nx;
   logic [IDX_W-1:0] idx_nx;

   always_comb begin
      state_nx = state;
      idx_nx   = idx;
      unique case (state)
         ST_IDLE: if (start) begin
            state_nx = ST_FETCH;
            idx_nx   = start_idx;
         end
         ST_FETCH: state_nx = cnt_zero ? ST_NEXT : ST_XFER;
         ST_XFER:  if (mm_ready && final_elem) state_nx = ST_NEXT;
         ST_NEXT: begin
            if (desc_last) begin
               state_nx = ST_FIN;
            end else begin
               state_nx = ST_FETCH;
               idx_nx   = (idx == IDX_W'(DEPTH-1)) ? '0 : idx + IDX_W'(1);
            end
         end
         ST_FIN:   state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         state <= state_nx;
         idx   <= idx_nx;
      end
   end

   assign load   = (state == ST_FETCH);
   assign active = (state == ST_XFER);
   assign step   = active && mm_ready;
   assign busy   = (state != ST_IDLE);
   assign done   = (state == ST_FIN);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   // R6
   stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mm_ready) |=> active);
   // R2
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);
   // R3
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load && !(state == ST_NEXT)) |=> $stable(idx));
endmodule

// File: rtl/strx_engine.sv
module strx_engine #(
   parameter int MM_AW    = 32,
   parameter int LM_AW    = 16,
   parameter int STRIDE_W = 16,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 8,
   parameter int N_MOD    = 4,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int SEL_W   = (N_MOD > 1) ? $clog2(N_MOD) : 1,
   localparam int DESC_W  = MM_AW + LM_AW + STRIDE_W + CNT_W + SEL_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_waddr,
   input  logic [DESC_W-1:0] cfg_wdata,
   input  logic [IDX_W-1:0]  cfg_raddr,
   output logic [DESC_W-1:0] cfg_rdata,
   input  logic              start,
   input  logic [IDX_W-1:0]  start_idx,
   output logic              busy,
   output logic              done,
   output logic              mm_req,
   output logic              mm_we,
   output logic [N_MOD-1:0]  mm_cs,
   output logic [MM_AW-1:0]  mm_addr,
   output logic [DATA_W-1:0] mm_wdata,
   input  logic [DATA_W-1:0] mm_rdata,
   input  logic              mm_ready,
   output logic              lm_req,
   output logic              lm_we,
   output logic [LM_AW-1:0]  lm_addr,
   output logic [DATA_W-1:0] lm_wdata,
   input  logic [DATA_W-1:0] lm_rdata
);
   localparam int O_SEL = 1;
   localparam int O_DIR = O_SEL + SEL_W;
   localparam int O_CNT = O_DIR + 1;
   localparam int O_STR = O_CNT + CNT_W;
   localparam int O_LMB = O_STR + STRIDE_W;
   localparam int O_MMB = O_LMB + LM_AW;

   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("strx_engine: DEPTH must be a power of two of at least 2");
      end
      if (N_MOD < 1 || N_MOD > (1 << SEL_W)) begin : g_bad_mod
         $error("strx_engine: N_MOD out of range");
      end
      if (STRIDE_W < 2 || CNT_W < 1 || LM_AW < 1 || MM_AW < 2) begin : g_bad_w
         $error("strx_engine: field widths too small");
      end
   endgenerate

   logic [IDX_W-1:0]    cur_idx;
   logic [DESC_W-1:0]   cur_desc;
   logic                load, step, active, final_elem;
   logic                d_last, d_dir;
   logic [SEL_W-1:0]    d_sel;
   logic [CNT_W-1:0]    d_cnt;
   logic [STRIDE_W-1:0] d_stride;
   logic [LM_AW-1:0]    d_lmb;
   logic [MM_AW-1:0]    d_mmb;

   assign d_last   = cur_desc[0];
   assign d_sel    = cur_desc[O_SEL +: SEL_W];
   assign d_dir    = cur_desc[O_DIR];
   assign d_cnt    = cur_desc[O_CNT +: CNT_W];
   assign d_stride = cur_desc[O_STR +: STRIDE_W];
   assign d_lmb    = cur_desc[O_LMB +: LM_AW];
   assign d_mmb    = cur_desc[O_MMB +: MM_AW];

   strx_desc_mem #(.DEPTH(DEPTH), .DESC_W(DESC_W)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock      (busy),
      .wr_en     (cfg_we),
      .wr_idx    (cfg_waddr),
      .wr_data   (cfg_wdata),
      .rd_idx_a  (cfg_raddr),
      .rd_data_a (cfg_rdata),
      .rd_idx_b  (cur_idx),
      .rd_data_b (cur_desc)
   );

   strx_seq #(.DEPTH(DEPTH)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_idx  (start_idx),
      .cnt_zero   (d_cnt == '0),
      .desc_last  (d_last),
      .final_elem (final_elem),
      .mm_ready   (mm_ready),
      .idx        (cur_idx),
      .load       (load),
      .step       (step),
      .active     (active),
      .busy       (busy),
      .done       (done)
   );

   strx_addr_gen #(.MM_AW(MM_AW), .LM_AW(LM_AW), .STRIDE_W(STRIDE_W), .CNT_W(CNT_W)) u_agen (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .step       (step),
      .mm_base    (d_mmb),
      .lm_base    (d_lmb),
      .stride     (d_stride),
      .count      (d_cnt),
      .mm_addr    (mm_addr),
      .lm_addr    (lm_addr),
      .final_elem (final_elem)
   );

   strx_cs_dec #(.N_MOD(N_MOD), .SEL_W(SEL_W)) u_cs (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (active),
      .sel   (d_sel),
      .cs    (mm_cs)
   );

   assign mm_req   = active;
   assign mm_we    = active && d_dir;
   assign lm_req   = active;
   assign lm_we    = active && !d_dir && mm_ready;
   assign mm_wdata = lm_rdata;
   assign lm_wdata = mm_rdata;

   // R5
   dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mm_we && lm_we));
   // R7
   cs_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mm_req |-> (mm_cs == '0));
endmodule

// File: tb/strx_engine_tb.sv
module strx_engine_tb;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_waddr = '0;
   logic [83:0] cfg_wdata = '0;
   logic [2:0]  cfg_raddr = '0;
   logic [83:0] cfg_rdata;
   logic        start = 1'b0;
   logic [2:0]  start_idx = '0;
   logic        busy, done;
   logic        mm_req, mm_we;
   logic [3:0]  mm_cs;
   logic [31:0] mm_addr, mm_wdata, mm_rdata;
   logic        mm_ready = 1'b1;
   logic        lm_req, lm_we;
   logic [15:0] lm_addr;
   logic [31:0] lm_wdata, lm_rdata;

   always #10 clk = ~clk;

   strx_engine u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
      .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .start(start), .start_idx(start_idx), .busy(busy), .done(done),
      .mm_req(mm_req), .mm_we(mm_we), .mm_cs(mm_cs), .mm_addr(mm_addr),
      .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_ready(mm_ready),
      .lm_req(lm_req), .lm_we(lm_we), .lm_addr(lm_addr),
      .lm_wdata(lm_wdata), .lm_rdata(lm_rdata)
   );

   function automatic logic [31:0] mm_pat(input logic [31:0] a);
      return (a * 32'd2654435761) ^ 32'hA5C3_0F1E;
   endfunction
   function automatic logic [31:0] lm_pat(input logic [15:0] a);
      return {~a, a} ^ 32'h1357_9BDF;
   endfunction
   assign mm_rdata = mm_pat(mm_addr);
   assign lm_rdata = lm_pat(lm_addr);

   function automatic logic [83:0] mk(input logic [31:0] mmb, input logic [15:0] lmb,
                                      input logic [15:0] str, input logic [15:0] cnt,
                                      input logic dir, input logic [1:0] sel, input logic last);
      return {mmb, lmb, str, cnt, dir, sel, last};
   endfunction

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int done_cnt = 0;
   bit stall_en = 1'b0;

   logic [83:0] shadow [DEPTH];
   logic [31:0] exp_mm  [1024];
   logic [15:0] exp_lm  [1024];
   logic        exp_dir [1024];
   logic [1:0]  exp_sel [1024];
   int exp_len = 0;
   int exp_ptr = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [83:0] act, input logic [83:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic build_exp(input int first);
      int i = first;
      exp_len = 0;
      exp_ptr = 0;
      for (int guard = 0; guard < 2 * DEPTH; guard++) begin
         logic [83:0] d = shadow[i];
         logic [31:0] sx = {{16{d[35]}}, d[35:20]};
         for (int k = 0; k < int'(d[19:4]); k++) begin
            exp_mm[exp_len]  = d[83:52] + 32'(k) * sx;
            exp_lm[exp_len]  = d[51:36] + 16'(k);
            exp_dir[exp_len] = d[3];
            exp_sel[exp_len] = d[2:1];
            exp_len++;
         end
         if (d[0]) break;
         i = (i + 1) % DEPTH;
      end
   endtask

   // monitor: drive ready, then check the handshake that the next edge takes
   logic        prev_stall = 1'b0;
   logic [31:0] prev_mm;
   logic [15:0] prev_lm;
   logic        prev_done = 1'b0;
   always @(negedge clk) begin
      mm_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (rst_n) begin
         if (prev_stall)
            chk(mm_req && mm_addr == prev_mm && lm_addr == prev_lm, "R6", "hold on stall",
                {mm_addr, lm_addr}, {prev_mm, prev_lm});
         if (mm_req && mm_ready) begin
            if (exp_ptr >= exp_len) begin
               chk(1'b0, "R9", "unexpected access", mm_addr, 0);
            end else begin
               chk(mm_addr == exp_mm[exp_ptr] && lm_addr == exp_lm[exp_ptr], "R4",
                   "element addresses", {mm_addr, lm_addr}, {exp_mm[exp_ptr], exp_lm[exp_ptr]});
               if (exp_dir[exp_ptr])
                  chk(mm_we && !lm_we && mm_wdata == lm_pat(lm_addr), "R5", "local to main",
                      {mm_we, lm_we, mm_wdata}, {1'b1, 1'b0, lm_pat(lm_addr)});
               else
                  chk(!mm_we && lm_we && lm_wdata == mm_pat(mm_addr), "R5", "main to local",
                      {mm_we, lm_we, lm_wdata}, {1'b0, 1'b1, mm_pat(mm_addr)});
               chk(mm_cs == (4'b1 << exp_sel[exp_ptr]), "R7", "chip select",
                   mm_cs, 4'b1 << exp_sel[exp_ptr]);
               exp_ptr++;
            end
         end
         if (!mm_req)
            chk(mm_cs == 4'b0, "R7", "no select when idle", mm_cs, 0);
         if (done) begin
            done_cnt++;
            chk(exp_ptr == exp_len, "R8", "all elements before done", exp_ptr, exp_len);
         end
         if (prev_done)
            chk(!done && !busy, "R10", "done single and idle after", {done, busy}, 0);
         prev_stall = mm_req && !mm_ready;
         prev_mm    = mm_addr;
         prev_lm    = lm_addr;
         prev_done  = done;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic wr(input int idx, input logic [83:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_waddr = 3'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      shadow[idx] = d;
   endtask

   // disturb: write slot 5 and pulse start mid-job
   task automatic run_job(input int first, input bit disturb);
      int dc = done_cnt;
      int w = 0;
      build_exp(first);
      @(negedge clk);
      start = 1'b1; start_idx = 3'(first);
      @(negedge clk);
      start = 1'b0;
      #2;
      chk(busy, "R2", "busy after start", busy, 1);
      while (done_cnt == dc && w < 4000) begin
         if (disturb && w == 4) begin
            cfg_we = 1'b1; cfg_waddr = 3'd5; cfg_wdata = ~shadow[5];
            start = 1'b1; start_idx = 3'd2;
         end else if (disturb && w == 5) begin
            cfg_we = 1'b0; start = 1'b0;
         end
         @(negedge clk);
         #2;
         w++;
      end
      chk(done_cnt == dc + 1, "R10", "done pulse seen", done_cnt - dc, 1);
      chk(exp_ptr == exp_len, "R4", "element count", exp_ptr, exp_len);
      @(negedge clk);
      #2;
      chk(!busy, "R10", "idle after job", busy, 0);
   endtask

   initial begin
      void'($urandom(32'd20240517));
      for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      #2;
      chk(!busy && !done && !mm_req && mm_cs == 4'b0, "R2", "reset state",
          {busy, done, mm_req, mm_cs}, 0);
      rst_n = 1'b1;

      // R1 write and read back
      wr(3, mk(32'h0000_1000, 16'h0040, 16'd3, 16'd5, 1'b0, 2'd0, 1'b1));
      cfg_raddr = 3'd3;
      #2;
      chk(cfg_rdata == shadow[3], "R1", "read back", cfg_rdata, shadow[3]);

      // single descriptor, positive stride, main to local
      run_job(3, 1'b0);

      // negative stride, local to main, module 3, with stalls (R6)
      wr(1, mk(32'h0000_0004, 16'hFFFE, 16'hFFFD, 16'd6, 1'b1, 2'd3, 1'b1));
      stall_en = 1'b1;
      run_job(1, 1'b0);

      // chain wrapping 6,7,0 with zero-count middle (R8, R9)
      wr(6, mk(32'h8000_0000, 16'h0100, 16'd16, 16'd3, 1'b0, 2'd1, 1'b0));
      wr(7, mk(32'hDEAD_0000, 16'h0200, 16'd1, 16'd0, 1'b1, 2'd2, 1'b0));
      wr(0, mk(32'hFFFF_FFFE, 16'h0300, 16'd1, 16'd4, 1'b1, 2'd2, 1'b1));
      run_job(6, 1'b0);

      // lone zero-count descriptor marked last (R9, R10)
      wr(2, mk(32'h1234_5678, 16'h0000, 16'd1, 16'd0, 1'b0, 2'd0, 1'b1));
      run_job(2, 1'b0);

      // long job with write and start mid-run (R2, R3)
      wr(4, mk(32'h0040_0000, 16'h0800, 16'd2, 16'd20, 1'b0, 2'd1, 1'b1));
      run_job(4, 1'b1);
      cfg_raddr = 3'd5;
      #2;
      chk(cfg_rdata == shadow[5], "R2", "write while busy ignored", cfg_rdata, shadow[5]);
      chk(done_cnt == 5, "R3", "start while busy ignored", done_cnt, 5);

      // random jobs
      for (int j = 0; j < 25; j++) begin
         int s = $urandom % DEPTH;
         int len = 1 + ($urandom % 3);
         stall_en = ($urandom % 2) != 0;
         for (int m = 0; m < len; m++)
            wr((s + m) % DEPTH, mk($urandom, 16'($urandom), 16'($urandom),
                                   16'($urandom % 7), 1'($urandom), 2'($urandom),
                                   m == len - 1));
         run_job(s, 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule